// File: doc/BRIEF.md
# Multidrop Address Wake-Up Unit

This unit sits between the character assembler of a serial receiver and its receive FIFO. In multidrop operation the bit that normally holds parity instead says whether a character is an address (1) or data (0). The unit looks at every character the assembler delivers. It decides whether that character goes into the FIFO. It also decides whether the receiver is currently listening.

Two ways of working are offered. In host mode every character is passed on with its address bit, and software acts on address characters itself. In automatic wake mode the hardware compares each address character with a programmed station address. A match wakes the receiver. The matching address character and the data after it are pushed into the FIFO. A mismatch puts the receiver to sleep, and data is then dropped. A match also sets a wake status flag, which drives the interrupt line only while interrupts are enabled.

A small write port programs the unit. Selector 0 is the mode register, where bits [1:0] hold the mode and bit 2 enables the interrupt. Selector 1 is the station address. Selector 2 clears status: writing bit 0 as 1 clears the wake flag.

Top module: `mdrop_wake`

## Requirements
- R1: After reset the mode is host (00), the interrupt is disabled, the wake flag and irq are 0, nothing is pushed, and rx_enabled is 1.
- R2: In host mode, and in the unused mode codes 10 and 11, every valid character is pushed one cycle later with fifo_data = {addr_flag, data}.
- R3: In automatic wake mode (01) the receiver starts asleep: rx_enabled is 0 and data characters (flag 0) are not pushed.
- R4: In mode 01, an address character equal to the station address is pushed one cycle later as {1, data}, and from that cycle on rx_enabled is 1 and the wake flag is 1.
- R5: While awake in mode 01, data characters are pushed one cycle later as {0, data}.
- R6: In mode 01, an address character that differs from the station address is not pushed, and from the next cycle rx_enabled is 0 and later data characters are dropped.
- R7: irq equals the wake flag ANDed with the interrupt enable (mode register bit 2), so a set flag with the enable off gives no interrupt.
- R8: Writing selector 2 with bit 0 set clears the wake flag. If a match occurs in the same cycle, the set wins.
- R9: The station address register is not changed by reset, so a value written before reset is still matched after it.
- R10: Any write to the mode register puts the receiver to sleep in the next cycle. A character arriving in the same cycle as the write is handled under the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector: 0 mode, 1 address, 2 status clear |
| cfg_wdata | input | DW | Write data |
| ch_valid | input | 1 | Received character strobe |
| ch_data | input | DW | Received character |
| ch_addr_flag | input | 1 | Address/data marker from the parity position |
| fifo_push | output | 1 | Push into the receive FIFO |
| fifo_data | output | DW+1 | Pushed word: {addr_flag, data} |
| rx_enabled | output | 1 | Receiver listening |
| wake_flag | output | 1 | Address recognized status |
| irq | output | 1 | Interrupt request |

## Verification
A wrong awake state shows up at rx_enabled in the cycle after the faulty update. It also shows at fifo_push on the next data character, because data is then dropped when it should be stored, or stored when it should be dropped. A bad address comparison shows one cycle after the address character, on the push, on rx_enabled and on the wake flag together. Errors in the flag or the enable appear on irq in the same cycle as the flag. The bench compares every output with a behavioural model on every clock, so each fault is reported in the cycle where it first becomes visible.

// File: rtl/mdrop_wake.sv
module mdrop_wake #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          ch_valid,
  input  logic [DW-1:0] ch_data,
  input  logic          ch_addr_flag,
  output logic          fifo_push,
  output logic [DW:0]   fifo_data,
  output logic          rx_enabled,
  output logic          wake_flag,
  output logic          irq
);
  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_ADDR  = 2'd1;
  localparam logic [1:0] SEL_CLR   = 2'd2;
  localparam logic [1:0] MODE_AUTO = 2'b01;

  logic [1:0]    mode_q;
  logic          ien_q;
  logic [DW-1:0] addr_q;
  logic          awake_q;

  wire auto_m  = (mode_q == MODE_AUTO);
  wire wr_mode = cfg_we && (cfg_sel == SEL_MODE);
  wire wr_addr = cfg_we && (cfg_sel == SEL_ADDR);
  wire wr_clr  = cfg_we && (cfg_sel == SEL_CLR) && cfg_wdata[0];
  wire is_adr  = auto_m && ch_valid && ch_addr_flag;
  wire match   = is_adr && (ch_data == addr_q);
  wire miss    = is_adr && (ch_data != addr_q);
  wire accept  = ch_valid && (!auto_m || match || (awake_q && !ch_addr_flag));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= 2'b00;
      ien_q  <= 1'b0;
    end else if (wr_mode) begin
      mode_q <= cfg_wdata[1:0];
      ien_q  <= cfg_wdata[2];
    end

  always_ff @(posedge clk)
    if (wr_addr) addr_q <= cfg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       awake_q <= 1'b0;
    else if (wr_mode) awake_q <= 1'b0;
    else if (match)   awake_q <= 1'b1;
    else if (miss)    awake_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      wake_flag <= 1'b0;
    else if (match)  wake_flag <= 1'b1;
    else if (wr_clr) wake_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fifo_push <= 1'b0;
      fifo_data <= '0;
    end else begin
      fifo_push <= accept;
      if (accept) fifo_data <= {ch_addr_flag, ch_data};
    end

  assign rx_enabled = !auto_m || awake_q;
  assign irq        = wake_flag && ien_q;

  AST_PUSH_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> $past(ch_valid)) else $error("push without char"); // R2
  AST_HOST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_AUTO && ch_valid) |=> (fifo_push && fifo_data == {$past(ch_addr_flag), $past(ch_data)}))
    else $error("host pass"); // R2
  AST_SLEEP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_m && !rx_enabled && ch_valid && !ch_addr_flag) |=> !fifo_push) else $error("sleep drop"); // R3
  AST_MATCH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_m && ch_valid && ch_addr_flag && ch_data == addr_q && !cfg_we)
      |=> (rx_enabled && wake_flag && fifo_push && fifo_data[DW])) else $error("match wake"); // R4
  AST_MISS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_m && ch_valid && ch_addr_flag && ch_data != addr_q && !cfg_we)
      |=> (!rx_enabled && !fifo_push)) else $error("miss sleep"); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake_flag) else $error("irq gating"); // R7
  AST_MODE_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && cfg_wdata[1:0] == MODE_AUTO) |=> !rx_enabled) else $error("mode write"); // R10
endmodule

// File: tb/sim_mdrop_wake.sv
module sim_mdrop_wake;
  localparam int DW = 8;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [DW-1:0] cfg_wdata = 0;
  logic ch_valid = 0; logic [DW-1:0] ch_data = 0; logic ch_addr_flag = 0;
  logic fifo_push; logic [DW:0] fifo_data; logic rx_enabled, wake_flag, irq;

  mdrop_wake #(.DW(DW)) u0 (.*);

  always #(TCLK/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string tag = "R1";

  int mode_m = 0, ien_m = 0, addr_m = -1, awake_m = 0, flag_m = 0, push_m = 0, data_m = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mode_m = 0; ien_m = 0; awake_m = 0; flag_m = 0; push_m = 0; data_m = 0;
    end else begin
      bit autom, hit;
      autom = (mode_m == 1);
      hit = (addr_m >= 0) && (int'(ch_data) == addr_m);
      push_m = 0;
      if (ch_valid) begin
        if (!autom) push_m = 1;
        else if (ch_addr_flag) push_m = hit;
        else push_m = awake_m;
      end
      if (push_m) data_m = {ch_addr_flag, ch_data};
      if (cfg_we && cfg_sel == 0) awake_m = 0;
      else if (autom && ch_valid && ch_addr_flag) awake_m = hit;
      if (autom && ch_valid && ch_addr_flag && hit) flag_m = 1;
      else if (cfg_we && cfg_sel == 2 && cfg_wdata[0]) flag_m = 0;
      if (cfg_we && cfg_sel == 0) begin mode_m = cfg_wdata[1:0]; ien_m = cfg_wdata[2]; end
      if (cfg_we && cfg_sel == 1) addr_m = cfg_wdata;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && cycles > 0) begin
    check(fifo_push == push_m, "fifo_push", fifo_push, push_m);
    if (push_m) check(fifo_data == data_m[DW:0], "fifo_data", fifo_data, data_m);
    check(rx_enabled == (mode_m != 1 || awake_m != 0), "rx_enabled", rx_enabled, (mode_m != 1 || awake_m != 0));
    check(wake_flag == flag_m, "wake_flag", wake_flag, flag_m);
    check(irq == (flag_m && ien_m), "irq", irq, (flag_m && ien_m));
  end

  task automatic step(input bit v, input int d, input bit f, input bit we, input int sel, input int wd);
    @(negedge clk);
    ch_valid = v; ch_data = d; ch_addr_flag = f;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    ch_valid = 0; cfg_we = 0;
  endtask
  task automatic chr(input int d, input bit f); step(1, d, f, 0, 0, 0); endtask
  task automatic cfg(input int sel, input int wd); step(0, 0, 0, 1, sel, wd); endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; repeat (2) @(negedge clk);
    check(rx_enabled && !wake_flag && !irq && !fifo_push, "reset state", 0, 1);
    tag = "R2"; chr(8'h11, 0); chr(8'h22, 1); chr(8'hA5, 0);
    cfg(0, 2'b10); chr(8'h3C, 1); chr(8'h3D, 0);
    cfg(1, 8'h5A);
    tag = "R3"; cfg(0, 3'b101); chr(8'h44, 0); chr(8'h45, 0);
    check(!rx_enabled, "asleep", rx_enabled, 0);
    tag = "R6"; chr(8'h33, 1); chr(8'h46, 0);
    tag = "R4"; chr(8'h5A, 1);
    check(rx_enabled && wake_flag, "woke", rx_enabled, 1);
    tag = "R5"; chr(8'h01, 0); chr(8'hFE, 0);
    tag = "R7"; check(irq, "irq on", irq, 1);
    tag = "R6"; chr(8'h5B, 1); chr(8'h02, 0); chr(8'h03, 0);
    tag = "R8"; cfg(2, 1);
    check(!wake_flag, "cleared", wake_flag, 0);
    step(1, 8'h5A, 1, 1, 2, 1);
    check(wake_flag, "set wins", wake_flag, 1);
    tag = "R7"; cfg(0, 3'b001); check(!irq, "irq gated", irq, 0);
    tag = "R10"; chr(8'h07, 0);
    step(1, 8'h08, 1, 1, 0, 3'b001); chr(8'h09, 0);
    chr(8'h5A, 1); step(1, 8'h0A, 0, 1, 0, 3'b001); chr(8'h0B, 0);
    cfg(0, 2'b11); chr(8'h0C, 0);
    tag = "R9"; rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    cfg(0, 3'b101); chr(8'h5A, 1); chr(8'h77, 0);
    check(wake_flag && irq, "addr kept", wake_flag, 1);
    repeat (3) @(negedge clk);
    finish_up();
  end

  initial begin
    #(TCLK * 5000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end
endmodule